// File: doc/BRIEF.md
# Bit count and scan unit

This unit answers one of three counting questions about a register operand: how many bits are one, how many zero bits sit above the highest one bit, and how many zero bits sit below the lowest one bit. A size select chooses whether the operand is 32 or 64 bits wide. Each count is defined for every input, including an all-zero operand. The unit also produces zero and carry flags for the result, and it always returns the overflow flag cleared.

A request is presented with `req_valid_i`, an operation code, the size select and the operand. The answer and its flags appear from a register one clock later, together with `res_valid_o`. A new request can be accepted on every clock, so the unit runs at full throughput without stalling.

Top module: `bit_count_unit`

## Requirements
- R1: Operation code 2'b00 (population) returns the number of one bits in the effective operand.
- R2: Operation code 2'b01 (leading) returns, for a nonzero operand, the width minus one minus the index of the highest set bit. The zero flag is set exactly when bit width-1 is one.
- R3: Operation code 2'b10 (trailing) returns, for a nonzero operand, the index of the lowest set bit. The zero flag is set exactly when bit 0 is one.
- R4: For codes 2'b01 and 2'b10, an all-zero effective operand returns the width (32 or 64) and sets the carry flag.
- R5: For codes 2'b01 and 2'b10, the carry flag is clear for a nonzero operand, and the zero flag equals (result == 0).
- R6: For code 2'b00, the zero flag is set exactly when the effective operand is zero, and the carry flag is always clear.
- R7: The overflow flag is 0 on every valid result.
- R8: With `wide_i` = 0 (32-bit size), operand bits 63:32 have no effect on the result or the flags. With either size, the result bits above the count are zero.
- R9: A request with `req_valid_i` high yields `res_valid_o` high on the next clock, along with its result. A cycle without a request yields `res_valid_o` low on the next clock. Back-to-back requests are all served.
- R10: While `rst_ni` is low, `res_valid_o`, `result_o`, `zf_o` and `cf_o` are 0.
- R11: The reserved code 2'b11 returns result 0 with the zero and carry flags clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request strobe |
| op_i | input | 2 | 00 population, 01 leading zeros, 10 trailing zeros, 11 reserved |
| wide_i | input | 1 | 1 = 64-bit operand, 0 = 32-bit operand |
| operand_i | input | 64 | Source operand |
| res_valid_o | output | 1 | Result valid, one clock after the request |
| result_o | output | 64 | Count, zero-extended |
| zf_o | output | 1 | Zero flag |
| cf_o | output | 1 | Carry flag |
| of_o | output | 1 | Overflow flag, always 0 |

## Verification
The bench aims at the all-zero operand for both scans and both sizes. A design built around a plain priority encoder would return a wrong count there and leave the carry flag clear. The bench drives single-bit operands at bit 0, bit 31 and bit 63 under each size. These catch off-by-one errors in the count and a zero flag that tests the wrong end of the operand. It drives 32-bit requests with random upper bits and with lower halves that are zero. A unit that leaked the upper half would count extra ones or would find a set bit above bit 31. Back-to-back requests, idle gaps and reserved codes expose a valid strobe or a result that is one cycle out of step with its request.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  typedef enum logic [1:0] {
    OP_POP  = 2'b00,
    OP_LEAD = 2'b01,
    OP_TRAIL = 2'b10
  } bcu_op_e;
endpackage

// File: rtl/bcu_ones.sv
module bcu_ones #(
  parameter int W     = 64,
  parameter int CNT_W = $clog2(W) + 1
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = '0;
    for (int i = 0; i < W; i++) cnt_o = cnt_o + CNT_W'(vec_i[i]);
  end
endmodule

// File: rtl/bcu_low_scan.sv
// Index of lowest set bit; W when the vector is all zero.
module bcu_low_scan #(
  parameter int W     = 64,
  parameter int CNT_W = $clog2(W) + 1
) (
  input  logic [W-1:0]     vec_i,
  output logic [CNT_W-1:0] cnt_o
);
  always_comb begin
    cnt_o = CNT_W'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) cnt_o = CNT_W'(i);
    end
  end
endmodule

// File: rtl/bit_count_unit.sv
module bit_count_unit #(
  parameter int DATA_W = 64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [1:0]        op_i,
  input  logic              wide_i,
  input  logic [DATA_W-1:0] operand_i,
  output logic              res_valid_o,
  output logic [DATA_W-1:0] result_o,
  output logic              zf_o,
  output logic              cf_o,
  output logic              of_o
);
  import bcu_pkg::*;

  localparam int HALF_W = DATA_W / 2;
  localparam int CNT_W  = $clog2(DATA_W) + 1;

  logic [DATA_W-1:0] pop_src, trail_src, lead_src, lead_rev;
  logic [CNT_W-1:0]  pop_cnt, trail_cnt, lead_cnt, width_cnt, cnt_d;
  logic              zf_d, cf_d;
  bcu_op_e           op;

  assign op = bcu_op_e'(op_i);

  // Narrow mode: pad so the scans stop at HALF_W on a zero lower half.
  assign pop_src   = wide_i ? operand_i : {{HALF_W{1'b0}}, operand_i[HALF_W-1:0]};
  assign trail_src = wide_i ? operand_i
                            : {{(HALF_W-1){1'b0}}, 1'b1, operand_i[HALF_W-1:0]};
  assign lead_src  = wide_i ? operand_i
                            : {operand_i[HALF_W-1:0], 1'b1, {(HALF_W-1){1'b0}}};
  assign width_cnt = wide_i ? CNT_W'(DATA_W) : CNT_W'(HALF_W);

  for (genvar g = 0; g < DATA_W; g++) begin : g_rev
    assign lead_rev[g] = lead_src[DATA_W-1-g];
  end

  bcu_ones #(.W(DATA_W), .CNT_W(CNT_W)) u_ones (
    .vec_i(pop_src), .cnt_o(pop_cnt)
  );
  bcu_low_scan #(.W(DATA_W), .CNT_W(CNT_W)) u_trail (
    .vec_i(trail_src), .cnt_o(trail_cnt)
  );
  bcu_low_scan #(.W(DATA_W), .CNT_W(CNT_W)) u_lead (
    .vec_i(lead_rev), .cnt_o(lead_cnt)
  );

  always_comb begin
    cnt_d = '0;
    zf_d  = 1'b0;
    cf_d  = 1'b0;
    unique case (op)
      OP_POP: begin
        cnt_d = pop_cnt;
        zf_d  = (pop_cnt == '0);
      end
      OP_LEAD: begin
        cnt_d = lead_cnt;
        zf_d  = (lead_cnt == '0);
        cf_d  = (lead_cnt == width_cnt);
      end
      OP_TRAIL: begin
        cnt_d = trail_cnt;
        zf_d  = (trail_cnt == '0);
        cf_d  = (trail_cnt == width_cnt);
      end
      default: ;
    endcase
  end

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_valid_o <= 1'b0;
      cnt_q       <= '0;
      zf_o        <= 1'b0;
      cf_o        <= 1'b0;
    end else begin
      res_valid_o <= req_valid_i;
      if (req_valid_i) begin
        cnt_q <= cnt_d;
        zf_o  <= zf_d;
        cf_o  <= cf_d;
      end
    end
  end

  assign result_o = {{(DATA_W-CNT_W){1'b0}}, cnt_q};
  assign of_o     = 1'b0;
endmodule

// File: rtl/bcu_checker.sv
module bcu_checker #(
  parameter int DATA_W = 64
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic [1:0]        op_i,
  input logic              wide_i,
  input logic [DATA_W-1:0] operand_i,
  input logic              res_valid_o,
  input logic              zf_o,
  input logic              cf_o
);
  localparam int HALF_W = DATA_W / 2;

  logic [DATA_W-1:0] eff;
  logic              top_bit;
  assign eff     = wide_i ? operand_i : {{HALF_W{1'b0}}, operand_i[HALF_W-1:0]};
  assign top_bit = wide_i ? operand_i[DATA_W-1] : operand_i[HALF_W-1];

  a_r9_valid_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_i |=> res_valid_o);
  a_r9_idle_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_valid_i |=> !res_valid_o);
  a_r4_carry_on_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && (op_i == 2'b01 || op_i == 2'b10)) |=> (cf_o == ($past(eff) == '0)));
  a_r6_pop_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 2'b00) |=> (!cf_o && zf_o == ($past(eff) == '0)));
  a_r2_lead_zf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 2'b01) |=> (zf_o == $past(top_bit)));
  a_r3_trail_zf: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 2'b10) |=> (zf_o == $past(operand_i[0])));
  a_r11_reserved_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && op_i == 2'b11) |=> (!zf_o && !cf_o));
endmodule

bind bit_count_unit bcu_checker #(.DATA_W(DATA_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .op_i(op_i),
  .wide_i(wide_i), .operand_i(operand_i), .res_valid_o(res_valid_o),
  .zf_o(zf_o), .cf_o(cf_o)
);

// File: tb/sim_bit_count_unit.sv
module sim_bit_count_unit;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        req_valid_i = 1'b0;
  logic [1:0]  op_i = 2'b00;
  logic        wide_i = 1'b0;
  logic [63:0] operand_i = '0;
  logic        res_valid_o, zf_o, cf_o, of_o;
  logic [63:0] result_o;

  int total = 0;
  int bad = 0;
  bit done = 0;

  logic        exp_v = 1'b0;
  logic [63:0] exp_r = '0;
  logic        exp_z = 1'b0, exp_c = 1'b0;
  string       exp_tag = "";

  always #5ns clk_i = ~clk_i;

  bit_count_unit u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .op_i(op_i),
    .wide_i(wide_i), .operand_i(operand_i), .res_valid_o(res_valid_o),
    .result_o(result_o), .zf_o(zf_o), .cf_o(cf_o), .of_o(of_o)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic void model(input logic [1:0] op, input logic w, input logic [63:0] x,
                                output logic [63:0] r, output logic z, output logic c,
                                output string tag);
    int n = w ? 64 : 32;
    int k = 0;
    bit seen = 0;
    bit any = 0;
    for (int i = 0; i < n; i++) if (x[i]) any = 1;
    r = '0; z = 0; c = 0;
    case (op)
      2'b00: begin
        for (int i = 0; i < n; i++) if (x[i]) k++;
        r = 64'(k); z = !any; tag = "R1 R6";
      end
      2'b01: begin
        for (int i = n - 1; i >= 0; i--) begin
          if (x[i]) seen = 1;
          if (!seen) k++;
        end
        r = 64'(k); z = (k == 0); c = !any; tag = any ? "R2 R5" : "R4";
      end
      2'b10: begin
        for (int i = 0; i < n; i++) begin
          if (x[i]) seen = 1;
          if (!seen) k++;
        end
        r = 64'(k); z = (k == 0); c = !any; tag = any ? "R3 R5" : "R4";
      end
      default: tag = "R11";
    endcase
    if (!w) tag = {tag, " R8"};
  endfunction

  task automatic step(input logic v, input logic [1:0] op, input logic w, input logic [63:0] x);
    logic [63:0] r;
    logic z, c;
    string tag;
    @(negedge clk_i);
    chk("R9 valid", 64'(res_valid_o), 64'(exp_v));
    if (exp_v) begin
      chk({exp_tag, " result"}, result_o, exp_r);
      chk({exp_tag, " zf"}, 64'(zf_o), 64'(exp_z));
      chk({exp_tag, " cf"}, 64'(cf_o), 64'(exp_c));
      chk("R7 of", 64'(of_o), 64'(0));
    end
    req_valid_i = v; op_i = op; wide_i = w; operand_i = x;
    model(op, w, x, r, z, c, tag);
    exp_v = v; exp_r = r; exp_z = z; exp_c = c; exp_tag = tag;
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    chk("R10 valid in reset", 64'(res_valid_o), 64'(0));
    chk("R10 result in reset", result_o, 64'(0));
    chk("R10 zf in reset", 64'(zf_o), 64'(0));
    chk("R10 cf in reset", 64'(cf_o), 64'(0));
    rst_ni = 1'b1;
    // R1 R6 population
    step(1, 2'b00, 1, 64'h0);
    step(1, 2'b00, 1, '1);
    step(1, 2'b00, 0, '1);
    step(1, 2'b00, 0, 64'hFFFF_FFFF_0000_0000);
    // R2 leading
    step(1, 2'b01, 1, 64'h8000_0000_0000_0000);
    step(1, 2'b01, 1, 64'h1);
    step(1, 2'b01, 0, 64'h1);
    step(1, 2'b01, 0, 64'h0000_0000_8000_0000);
    // R4 zero sources
    step(1, 2'b01, 1, 64'h0);
    step(1, 2'b01, 0, 64'hDEAD_BEEF_0000_0000);
    step(1, 2'b10, 1, 64'h0);
    step(1, 2'b10, 0, 64'hFFFF_FFFF_0000_0000);
    // R3 trailing
    step(1, 2'b10, 1, 64'h8000_0000_0000_0000);
    step(1, 2'b10, 1, 64'h1);
    step(1, 2'b10, 0, 64'h0000_0000_8000_0000);
    // R11 reserved, R9 gaps
    step(1, 2'b11, 1, '1);
    step(0, 2'b00, 1, '1);
    step(1, 2'b11, 0, 64'h0);
    step(0, 2'b01, 0, 64'h0);
    for (int i = 0; i < 400; i++) begin
      logic [63:0] x = {$urandom(), $urandom()};
      int sh = $urandom_range(0, 63);
      if (i % 3 == 1) x = x >> sh;
      if (i % 3 == 2) x = x << sh;
      step(($urandom_range(0, 7) != 0), 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)), x);
    end
    step(0, 2'b00, 0, '0);
    step(0, 2'b00, 0, '0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule